// File: doc/BRIEF.md
# Integer Execute Unit with Condition Flags

This block is the integer execute stage of a 32-bit load/store core with sixteen general registers. Each cycle it takes a decoded four-bit operation code, two modifier bits (`mod_u`, `mod_v`) and a first operand `opb`. The second operand comes either from a register value `reg_n` or from a 16-bit constant `imm16`, which the block extends itself. It also takes the current condition flags and the multiply-high register H. It returns the value to write to the destination register, the next H value and the next condition flags.

All outputs are registered once, so a result appears one clock after its operands. The modifier bits change the meaning of some codes. The move code can read H, read the flags, or place a constant in the upper half. Add and subtract gain forms that consume the carry. Multiply becomes unsigned. Codes the block does not implement (divide and the four floating-point codes) raise `unsupported` and leave the architectural state untouched.

Top module: `int_alu_exec`

## Requirements
- R1: With `imm_sel`=1 the second operand is `imm16` in bits 15:0, with bits 31:16 all zero when `mod_v`=0 and all one when `mod_v`=1. With `imm_sel`=0 it is `reg_n`.
- R2: Code 4 yields B AND N, code 5 yields B AND NOT N, code 6 yields B OR N, and code 7 yields B XOR N.
- R3: Code 1 shifts B left, code 2 shifts B right while copying the sign bit, and code 3 rotates B right. All three use only bits 4:0 of N as the amount.
- R4: Code 0 with `mod_u`=0 yields N. With `mod_u`=1 and the immediate form it yields `imm16` shifted left by 16. With `mod_u`=1 in register form it yields H when `mod_v`=0, or {N,Z,C,V flags in bits 31:28} ORed with parameter INFO (default 0x53) when `mod_v`=1.
- R5: Code 8 yields B+N and code 9 yields B−N. With `mod_u`=1 the incoming carry (`flags_in[1]`) is added by code 8 and subtracted by code 9. The C flag is the carry out of an add and the borrow of a subtract.
- R6: The V flag is set on add when B and N share a sign and the result sign differs. On subtract it is set when B and N differ in sign and the result sign differs from B.
- R7: Code 10 writes the low 32 bits of the product to the result and the high 32 bits to `h_out`. The product is signed when `mod_u`=0 and unsigned when `mod_u`=1. Every other code passes `h_in` to `h_out`.
- R8: Flag bits are N=3, Z=2, C=1, V=0. Every supported code sets N to result bit 31 and sets Z when the result is zero. C and V are copied from `flags_in` except on codes 8 and 9.
- R9: Codes 11 to 15 set `unsupported`, give a zero result, and copy `flags_in` and `h_in` to the outputs unchanged.
- R10: Outputs reflect the inputs of the previous clock edge. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| mod_u | input | 1 | First modifier bit |
| mod_v | input | 1 | Second modifier bit |
| imm_sel | input | 1 | 1 selects the extended immediate as operand N |
| opb | input | 32 | Operand B |
| reg_n | input | 32 | Register-form operand N |
| imm16 | input | 16 | Immediate constant |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| h_in | input | 32 | Current H register |
| result | output | 32 | Value for the destination register |
| h_out | output | 32 | Next H value |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| unsupported | output | 1 | Operation code not implemented here |

## Verification
The properties assume the inputs are stable and known at every clock edge after reset. They also assume the previous cycle's inputs fully determine the current outputs, with no hold or stall. The stimulus meets both conditions: it changes every input only on the falling edge and drives each field from $urandom over its whole range, so all sixteen codes and both modifier values occur. A set of directed vectors adds the edges that random values rarely reach: overflow at the sign boundary, zero borrow, shift amounts above 31, and all-ones multiplies.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
    localparam logic [3:0] OP_MOV = 4'd0;
    localparam logic [3:0] OP_LSL = 4'd1;
    localparam logic [3:0] OP_ASR = 4'd2;
    localparam logic [3:0] OP_ROR = 4'd3;
    localparam logic [3:0] OP_AND = 4'd4;
    localparam logic [3:0] OP_ANN = 4'd5;
    localparam logic [3:0] OP_IOR = 4'd6;
    localparam logic [3:0] OP_XOR = 4'd7;
    localparam logic [3:0] OP_ADD = 4'd8;
    localparam logic [3:0] OP_SUB = 4'd9;
    localparam logic [3:0] OP_MUL = 4'd10;
    localparam logic [3:0] OP_LAST_OK = 4'd10;

    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_C = 1;
    localparam int FL_V = 0;
endpackage

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   sh_left,
    output logic [W-1:0]   sh_arith,
    output logic [W-1:0]   rot_right
);
    logic [2*W-1:0] doubled;

    always_comb begin
        sh_left   = val << amt;
        sh_arith  = $signed(val) >>> amt;
        doubled   = {val, val} >> amt;
        rot_right = doubled[W-1:0];
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    input  logic         cin,
    input  logic         use_cin,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         c_flag,
    output logic         v_flag
);
    logic [W-1:0] n_eff;
    logic         c_eff;
    logic         co;

    always_comb begin
        n_eff     = do_sub ? ~n : n;
        c_eff     = do_sub ? ~(use_cin & cin) : (use_cin & cin);
        {co, sum} = {1'b0, b} + {1'b0, n_eff} + {{W{1'b0}}, c_eff};
        c_flag    = do_sub ? ~co : co;
        if (do_sub)
            v_flag = (b[W-1] != n[W-1]) && (sum[W-1] != b[W-1]);
        else
            v_flag = (b[W-1] == n[W-1]) && (sum[W-1] != b[W-1]);
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_unsigned,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic [2*W-1:0] a_ext;
    logic [2*W-1:0] b_ext;
    logic [2*W-1:0] prod;

    always_comb begin
        a_ext = is_unsigned ? {{W{1'b0}}, a} : {{W{a[W-1]}}, a};
        b_ext = is_unsigned ? {{W{1'b0}}, b} : {{W{b[W-1]}}, b};
        prod  = a_ext * b_ext;
        lo    = prod[W-1:0];
        hi    = prod[2*W-1:W];
    end
endmodule

// File: rtl/int_alu_exec.sv
module int_alu_exec
    import alu_exec_pkg::*;
#(
    parameter int          W     = 32,
    parameter int          IMM_W = 16,
    parameter logic [31:0] INFO  = 32'h0000_0053
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op,
    input  logic             mod_u,
    input  logic             mod_v,
    input  logic             imm_sel,
    input  logic [W-1:0]     opb,
    input  logic [W-1:0]     reg_n,
    input  logic [IMM_W-1:0] imm16,
    input  logic [3:0]       flags_in,
    input  logic [W-1:0]     h_in,
    output logic [W-1:0]     result,
    output logic [W-1:0]     h_out,
    output logic [3:0]       flags_out,
    output logic             unsupported
);
    localparam int SHW   = $clog2(W);
    localparam int FILLW = W - IMM_W;

    typedef struct packed {
        logic [W-1:0] res;
        logic [W-1:0] h;
        logic [3:0]   fl;
        logic         unsup;
    } exec_state_t;

    exec_state_t st_d, st_q;

    logic [W-1:0] n_val;
    logic [W-1:0] sh_l, sh_a, rot_r;
    logic [W-1:0] as_sum;
    logic         as_c, as_v;
    logic [W-1:0] mul_lo, mul_hi;
    logic [W-1:0] info_w;

    assign info_w = W'(INFO);
    assign n_val  = imm_sel ? {{FILLW{mod_v}}, imm16} : reg_n;

    alu_shifter #(.W(W)) u_shift (
        .val      (opb),
        .amt      (n_val[SHW-1:0]),
        .sh_left  (sh_l),
        .sh_arith (sh_a),
        .rot_right(rot_r)
    );

    alu_adder #(.W(W)) u_add (
        .b      (opb),
        .n      (n_val),
        .cin    (flags_in[FL_C]),
        .use_cin(mod_u),
        .do_sub (op == OP_SUB),
        .sum    (as_sum),
        .c_flag (as_c),
        .v_flag (as_v)
    );

    alu_mul #(.W(W)) u_mul (
        .a          (opb),
        .b          (n_val),
        .is_unsigned(mod_u),
        .lo         (mul_lo),
        .hi         (mul_hi)
    );

    always_comb begin
        st_d       = '0;
        st_d.h     = h_in;
        st_d.fl    = flags_in;
        st_d.unsup = 1'b0;
        unique case (op)
            OP_MOV: begin
                if (!mod_u)
                    st_d.res = n_val;
                else if (imm_sel)
                    st_d.res = {imm16, {FILLW{1'b0}}};
                else if (!mod_v)
                    st_d.res = h_in;
                else
                    st_d.res = {flags_in, {(W-4){1'b0}}} | info_w;
            end
            OP_LSL: st_d.res = sh_l;
            OP_ASR: st_d.res = sh_a;
            OP_ROR: st_d.res = rot_r;
            OP_AND: st_d.res = opb & n_val;
            OP_ANN: st_d.res = opb & ~n_val;
            OP_IOR: st_d.res = opb | n_val;
            OP_XOR: st_d.res = opb ^ n_val;
            OP_ADD, OP_SUB: begin
                st_d.res      = as_sum;
                st_d.fl[FL_C] = as_c;
                st_d.fl[FL_V] = as_v;
            end
            OP_MUL: begin
                st_d.res = mul_lo;
                st_d.h   = mul_hi;
            end
            default: begin
                st_d.res   = '0;
                st_d.unsup = 1'b1;
            end
        endcase
        if (!st_d.unsup) begin
            st_d.fl[FL_N] = st_d.res[W-1];
            st_d.fl[FL_Z] = (st_d.res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result      = st_q.res;
    assign h_out       = st_q.h;
    assign flags_out   = st_q.fl;
    assign unsupported = st_q.unsup;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_exec_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op,
    input logic [3:0]   flags_in,
    input logic [W-1:0] h_in,
    input logic [W-1:0] result,
    input logic [W-1:0] h_out,
    input logic [3:0]   flags_out,
    input logic         unsupported
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_unsup_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (unsupported == ($past(op) > OP_LAST_OK)));

    p_unsup_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && unsupported) |->
            (result == '0 && flags_out == $past(flags_in) && h_out == $past(h_in)));

    p_cv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op) != OP_ADD && $past(op) != OP_SUB) |->
            (flags_out[FL_C] == $past(flags_in[FL_C]) && flags_out[FL_V] == $past(flags_in[FL_V])));

    p_nz_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !unsupported) |->
            (flags_out[FL_N] == result[W-1] && flags_out[FL_Z] == (result == '0)));

    p_h_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op) != OP_MUL) |-> (h_out == $past(h_in)));
endmodule

bind int_alu_exec alu_exec_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .flags_in   (flags_in),
    .h_in       (h_in),
    .result     (result),
    .h_out      (h_out),
    .flags_out  (flags_out),
    .unsupported(unsupported)
);

// File: tb/tb_int_alu_exec.sv
`timescale 1ns/1ps
module tb_int_alu_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic        mod_u = 1'b0, mod_v = 1'b0, imm_sel = 1'b0;
    logic [31:0] opb = '0, reg_n = '0, h_in = '0;
    logic [15:0] imm16 = '0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result, h_out;
    logic [3:0]  flags_out;
    logic        unsupported;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    int_alu_exec dut (
        .clk(clk), .rst_n(rst_n), .op(op), .mod_u(mod_u), .mod_v(mod_v),
        .imm_sel(imm_sel), .opb(opb), .reg_n(reg_n), .imm16(imm16),
        .flags_in(flags_in), .h_in(h_in), .result(result), .h_out(h_out),
        .flags_out(flags_out), .unsupported(unsupported)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (op=%0d u=%0b v=%0b imm=%0b)",
                     req, act, exp, op, mod_u, mod_v, imm_sel);
        end
    endtask

    task automatic model(output logic [31:0] r, output logic [31:0] h,
                         output logic [3:0] f, output logic uns);
        logic [31:0] nv;
        logic [4:0]  sh;
        logic [32:0] t;
        logic [63:0] p, dbl;
        logic signed [31:0] sb;
        logic        cin;
        nv  = imm_sel ? {(mod_v ? 16'hFFFF : 16'h0000), imm16} : reg_n;
        sh  = nv[4:0];
        sb  = opb;
        cin = mod_u ? flags_in[1] : 1'b0;
        h   = h_in;
        f   = flags_in;
        uns = 1'b0;
        r   = '0;
        case (op)
            4'd0: if (!mod_u) r = nv;
                  else if (imm_sel) r = {imm16, 16'h0000};
                  else if (!mod_v) r = h_in;
                  else r = {flags_in, 28'h0} | 32'h53;
            4'd1: r = opb << sh;
            4'd2: r = sb >>> sh;
            4'd3: begin dbl = {opb, opb} >> sh; r = dbl[31:0]; end
            4'd4: r = opb & nv;
            4'd5: r = opb & ~nv;
            4'd6: r = opb | nv;
            4'd7: r = opb ^ nv;
            4'd8: begin
                t = {1'b0, opb} + {1'b0, nv} + {32'd0, cin};
                r = t[31:0]; f[1] = t[32];
                f[0] = (opb[31] == nv[31]) && (r[31] != opb[31]);
            end
            4'd9: begin
                t = {1'b0, opb} - {1'b0, nv} - {32'd0, cin};
                r = t[31:0]; f[1] = t[32];
                f[0] = (opb[31] != nv[31]) && (r[31] != opb[31]);
            end
            4'd10: begin
                if (mod_u) p = {32'd0, opb} * {32'd0, nv};
                else p = 64'($signed(longint'($signed(opb)) * longint'($signed(nv))));
                r = p[31:0]; h = p[63:32];
            end
            default: uns = 1'b1;
        endcase
        if (!uns) begin
            f[3] = r[31];
            f[2] = (r == 32'd0);
        end
    endtask

    function automatic string op_tag(logic [3:0] o);
        case (o)
            4'd0: return "R4";
            4'd1, 4'd2, 4'd3: return "R3";
            4'd4, 4'd5, 4'd6, 4'd7: return "R2";
            4'd8, 4'd9: return "R5";
            4'd10: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic apply(string tag, logic [3:0] o, logic u, logic v, logic is,
                         logic [31:0] b, logic [31:0] rn, logic [15:0] im,
                         logic [3:0] fl, logic [31:0] h);
        logic [31:0] er, eh;
        logic [3:0]  ef;
        logic        eu;
        op = o; mod_u = u; mod_v = v; imm_sel = is;
        opb = b; reg_n = rn; imm16 = im; flags_in = fl; h_in = h;
        model(er, eh, ef, eu);
        @(posedge clk);
        @(negedge clk);
        chk(tag, result, er);
        chk("R7", h_out, eh);
        chk("R8", {28'd0, flags_out[3:2]}, {28'd0, ef[3:2]});
        chk("R5", {31'd0, flags_out[1]}, {31'd0, ef[1]});
        chk("R6", {31'd0, flags_out[0]}, {31'd0, ef[0]});
        chk("R9", {31'd0, unsupported}, {31'd0, eu});
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (2) @(negedge clk);
        chk("R10", result, 32'd0);
        chk("R10", h_out, 32'd0);
        chk("R10", {28'd0, flags_out}, 32'd0);
        chk("R10", {31'd0, unsupported}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 immediate extension
        apply("R1", 4'd0, 0, 0, 1, 32'h0, 32'h0, 16'h8001, 4'h0, 32'h0);
        apply("R1", 4'd0, 0, 1, 1, 32'h0, 32'h0, 16'h1234, 4'h0, 32'h0);
        apply("R1", 4'd6, 0, 1, 1, 32'h0000_00F0, 32'h0, 16'h000F, 4'h0, 32'h0);
        // R4 move variants
        apply("R4", 4'd0, 1, 0, 1, 32'h0, 32'h0, 16'hBEEF, 4'h0, 32'h0);
        apply("R4", 4'd0, 1, 0, 0, 32'h0, 32'h0, 16'h0, 4'h0, 32'hCAFE_0001);
        apply("R4", 4'd0, 1, 1, 0, 32'h0, 32'h0, 16'h0, 4'hA, 32'h0);
        // R3 shifts, amount limited to five bits
        apply("R3", 4'd2, 0, 0, 0, 32'h8000_0010, 32'd4, 16'h0, 4'h0, 32'h0);
        apply("R3", 4'd3, 0, 0, 0, 32'h0000_0001, 32'd33, 16'h0, 4'h0, 32'h0);
        apply("R3", 4'd1, 0, 0, 0, 32'h0000_0003, 32'd63, 16'h0, 4'h0, 32'h0);
        apply("R3", 4'd3, 0, 0, 0, 32'h1234_5678, 32'd0, 16'h0, 4'h0, 32'h0);
        // R2 and-not
        apply("R2", 4'd5, 0, 0, 0, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 16'h0, 4'h0, 32'h0);
        // R5 R6 arithmetic corners
        apply("R6", 4'd8, 0, 0, 0, 32'h7FFF_FFFF, 32'd1, 16'h0, 4'h0, 32'h0);
        apply("R5", 4'd8, 1, 0, 0, 32'hFFFF_FFFF, 32'd0, 16'h0, 4'h2, 32'h0);
        apply("R5", 4'd9, 0, 0, 0, 32'd0, 32'd1, 16'h0, 4'h0, 32'h0);
        apply("R5", 4'd9, 1, 0, 0, 32'd5, 32'd5, 16'h0, 4'h2, 32'h0);
        apply("R6", 4'd9, 0, 0, 0, 32'h8000_0000, 32'd1, 16'h0, 4'h0, 32'h0);
        // R7 multiply
        apply("R7", 4'd10, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 4'h0, 32'h55);
        apply("R7", 4'd10, 1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 4'h0, 32'h55);
        apply("R7", 4'd10, 0, 0, 0, 32'h8000_0000, 32'd2, 16'h0, 4'h0, 32'h0);
        // R9 unsupported codes
        apply("R9", 4'd11, 0, 0, 0, 32'd9, 32'd3, 16'h0, 4'hF, 32'h77);
        apply("R9", 4'd15, 1, 1, 1, 32'd9, 32'd3, 16'h5, 4'h6, 32'h88);

        for (int i = 0; i < 400; i++) begin
            logic [3:0] o;
            o = 4'($urandom);
            apply(op_tag(o), o, 1'($urandom), 1'($urandom), 1'($urandom),
                  $urandom, $urandom, 16'($urandom), 4'($urandom), $urandom);
        end

        // R10 reset returns outputs to zero
        rst_n = 1'b0;
        #1;
        chk("R10", result | h_out | {28'd0, flags_out}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule